// File: doc/BRIEF.md
# Two-Bank Frame Handoff Buffer

This block sits between a stage that produces frames and a stage that consumes them, so that both stages can work at once. It holds two banks, each as deep as one frame. The producer writes the elements of a frame into the bank it currently owns, in any address order. It then pulses a commit strobe, which hands the whole bank to the consumer side in one step and moves the producer to the other bank. The consumer reads elements from the committed bank by address and pulses a release strobe when it is done. Release returns that bank to the empty state and moves the consumer on.

Bank ownership alternates on each side. While the consumer drains frame N from one bank, the producer can fill frame N+1 in the other bank. A full flag tells the producer to stall. An available flag tells the consumer that its bank holds a committed frame.

Each bank is a simple dual-port memory with one write port and one read port. Reads have one cycle of latency. A read of an address that is being written in the same cycle returns the old contents.

Top module: `pp_frame_buf`

## Requirements
- R1: After reset both banks are empty, `prodFull` and `consAvail` are 0, and `prodBank` and `consBank` are both 0.
- R2: A commit while the producer's bank is empty marks that bank full and flips `prodBank` on the next cycle.
- R3: `prodFull` is 1 exactly while the producer's current bank is full. A commit while `prodFull` is 1 changes nothing.
- R4: A write strobe while `prodFull` is 1 does not alter any bank's contents.
- R5: A release while `consAvail` is 1 marks the consumer's bank empty and flips `consBank`. A release while `consAvail` is 0 changes nothing.
- R6: `consAvail` is 1 exactly while the consumer's current bank is full.
- R7: `consData` shows the word at `consAddr` in bank `consBank` one clock edge after the address is presented.
- R8: When the producer writes an address in the same cycle that the consumer reads that address of the same bank, the read returns the value held before the write.
- R9: A commit and a release accepted in the same cycle both take effect, so the number of full banks does not change.
- R10: Frames reach the consumer in commit order, with the banks used alternately starting at bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| prodWrEn | input | 1 | Producer element write strobe |
| prodAddr | input | ADDR_W | Producer element address |
| prodData | input | DATA_W | Producer element data |
| prodCommit | input | 1 | Hand the producer's bank over as a full frame |
| prodFull | output | 1 | Producer's bank is still full; stall |
| prodBank | output | 1 | Bank the producer owns |
| consAddr | input | ADDR_W | Consumer read address |
| consData | output | DATA_W | Read data, one cycle after the address |
| consRelease | input | 1 | Return the consumer's bank as empty |
| consAvail | output | 1 | Consumer's bank holds a committed frame |
| consBank | output | 1 | Bank the consumer owns |

## Verification
The bench targets the strobes that arrive at the wrong moment. A commit into a full bank would corrupt a waiting frame and flip the producer pointer early. A release on an empty bank would skip a bank and deliver frames out of order. A simultaneous commit and release that drops one of the two updates would leave a bank stuck full or silently lose a frame.

Writes issued during a stall are checked by reading the frame back; a design that lets them through shows the stray value. The same-cycle read and write of one address checks that the old word is returned; a memory that forwards the new data would show it one cycle early.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int NUM_BANKS = 2;

  typedef struct packed {
    logic [NUM_BANKS-1:0] wrBankEn;
    logic                 rdBank;
  } ppStrobes_t;
endpackage

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       prodWrEn,
  input  logic       prodCommit,
  input  logic       consRelease,
  output logic       prodFull,
  output logic       consAvail,
  output logic       prodBank,
  output logic       consBank,
  output ppStrobes_t strobes
);
  logic [NUM_BANKS-1:0] bankFull;
  logic                 prodPtr;
  logic                 consPtr;
  logic                 commitOk;
  logic                 releaseOk;

  assign prodFull  = bankFull[prodPtr];
  assign consAvail = bankFull[consPtr];
  assign commitOk  = prodCommit && !prodFull;
  assign releaseOk = consRelease && consAvail;
  assign prodBank  = prodPtr;
  assign consBank  = consPtr;

  always_comb begin
    strobes.rdBank = consPtr;
    for (int b = 0; b < NUM_BANKS; b++) begin
      strobes.wrBankEn[b] = prodWrEn && !prodFull && (prodPtr == 1'(b));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankFull <= '0;
      prodPtr  <= 1'b0;
      consPtr  <= 1'b0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (commitOk && prodPtr == 1'(b)) bankFull[b] <= 1'b1;
        else if (releaseOk && consPtr == 1'(b)) bankFull[b] <= 1'b0;
      end
      if (commitOk)  prodPtr <= ~prodPtr;
      if (releaseOk) consPtr <= ~consPtr;
    end
  end

  // R2: an accepted commit moves the producer to the other bank
  assert_commit_flip_R2: assert property (@(posedge clk) disable iff (!rstN)
    prodCommit && !prodFull |=> prodBank != $past(prodBank));

  // R3: a commit during a stall leaves the producer where it is
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    prodCommit && prodFull |=> $stable(prodBank));

  // R4: no bank is written while the producer is stalled
  assert_write_blocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    prodFull |-> strobes.wrBankEn == '0);

  // R5: an accepted release moves the consumer on
  assert_release_flip_R5: assert property (@(posedge clk) disable iff (!rstN)
    consRelease && consAvail |=> consBank != $past(consBank));

  // R5: a release on an empty bank is ignored
  assert_release_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    consRelease && !consAvail |=> $stable(consBank) && $stable(bankFull));

  // R9: a simultaneous commit and release keep the full count unchanged
  assert_both_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    commitOk && releaseOk |=> $countones(bankFull) == $past($countones(bankFull)));
endmodule

// File: rtl/pp_datapath.sv
module pp_datapath
  import pp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  ppStrobes_t        strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] bankRd [NUM_BANKS];
  logic              rdSelQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdQ;

    // registered read sees the word held before a same-cycle write
    always_ff @(posedge clk) begin
      if (strobes.wrBankEn[b]) mem[wrAddr] <= wrData;
      rdQ <= mem[rdAddr];
    end

    assign bankRd[b] = rdQ;
  end

  always_ff @(posedge clk) rdSelQ <= strobes.rdBank;

  assign rdData = bankRd[rdSelQ];

  // R4: the control never enables both bank write ports together
  assert_one_writer_R4: assert property (@(posedge clk)
    $onehot0(strobes.wrBankEn));
endmodule

// File: rtl/pp_frame_buf.sv
module pp_frame_buf
  import pp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prodWrEn,
  input  logic [ADDR_W-1:0] prodAddr,
  input  logic [DATA_W-1:0] prodData,
  input  logic              prodCommit,
  output logic              prodFull,
  output logic              prodBank,
  input  logic [ADDR_W-1:0] consAddr,
  output logic [DATA_W-1:0] consData,
  input  logic              consRelease,
  output logic              consAvail,
  output logic              consBank
);
  ppStrobes_t strobes;

  pp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .prodWrEn(prodWrEn), .prodCommit(prodCommit),
    .consRelease(consRelease), .prodFull(prodFull), .consAvail(consAvail),
    .prodBank(prodBank), .consBank(consBank), .strobes(strobes)
  );

  pp_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .strobes(strobes), .wrAddr(prodAddr), .wrData(prodData),
    .rdAddr(consAddr), .rdData(consData)
  );
endmodule

// File: tb/test_pp_frame_buf.sv
module test_pp_frame_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = $clog2(DEPTH);

  // row: {op[1:0], prodFull, consAvail, prodBank, consBank} after the op
  // op: 0 idle, 1 commit, 2 release, 3 commit+release
  localparam logic [5:0] STEP_TAB [12] = '{
    6'b00_0000, 6'b10_0000, 6'b01_0110, 6'b01_1100,
    6'b01_1100, 6'b10_0101, 6'b11_0110, 6'b10_0011,
    6'b10_0011, 6'b01_0101, 6'b11_0110, 6'b10_0011
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic prodWrEn = 1'b0;
  logic [ADDR_W-1:0] prodAddr = '0;
  logic [DATA_W-1:0] prodData = '0;
  logic prodCommit = 1'b0;
  logic prodFull, prodBank, consAvail, consBank;
  logic [ADDR_W-1:0] consAddr = '0;
  logic [DATA_W-1:0] consData;
  logic consRelease = 1'b0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_frame_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_pp_frame_buf (
    .clk(clk), .rstN(rstN), .prodWrEn(prodWrEn), .prodAddr(prodAddr),
    .prodData(prodData), .prodCommit(prodCommit), .prodFull(prodFull),
    .prodBank(prodBank), .consAddr(consAddr), .consData(consData),
    .consRelease(consRelease), .consAvail(consAvail), .consBank(consBank)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic strobe(input logic cm, input logic rl);
    prodCommit = cm;
    consRelease = rl;
    @(negedge clk);
    prodCommit = 1'b0;
    consRelease = 1'b0;
  endtask

  task automatic writeWord(input int a, input logic [DATA_W-1:0] d);
    prodWrEn = 1'b1;
    prodAddr = ADDR_W'(a);
    prodData = d;
    @(negedge clk);
    prodWrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input int a, input logic [DATA_W-1:0] exp);
    consAddr = ADDR_W'(a);
    @(negedge clk);
    chk(req, 32'(consData), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R1: reset state
    chk("R1", {prodFull, consAvail, prodBank, consBank}, 4'b0000);

    // table walk covering R2 R3 R5 R6 R9
    for (int i = 0; i < 12; i++) begin
      logic [1:0] op;
      op = STEP_TAB[i][5:4];
      strobe(op[0], op[1]);
      chk($sformatf("R2/R3/R5/R6/R9 step %0d", i),
          {prodFull, consAvail, prodBank, consBank}, STEP_TAB[i][3:0]);
    end

    doReset();
    // fill bank 0 with frame A and bank 1 with frame B (R10)
    for (int i = 0; i < DEPTH; i++) writeWord(i, DATA_W'(16'h1000 + i));
    strobe(1'b1, 1'b0);
    for (int i = 0; i < DEPTH; i++) writeWord(i, DATA_W'(16'h2000 + i));
    strobe(1'b1, 1'b0);
    chk("R3", 32'(prodFull), 32'd1);
    // R4: writes during the stall must be dropped
    writeWord(0, 16'hDEAD);
    writeWord(5, 16'hBEEF);
    chk("R6", 32'(consAvail), 32'd1);
    // R7 R10: frame A from bank 0, one-cycle read latency
    for (int i = 0; i < DEPTH; i++) readCheck("R7/R10", i, DATA_W'(16'h1000 + i));
    readCheck("R4", 0, 16'h1000);
    strobe(1'b0, 1'b1);
    chk("R10", 32'(consBank), 32'd1);
    for (int i = 0; i < DEPTH; i++) readCheck("R10", i, DATA_W'(16'h2000 + i));
    readCheck("R4", 5, 16'h2005);
    strobe(1'b0, 1'b1);
    chk("R5", {prodFull, consAvail, prodBank, consBank}, 4'b0000);

    // R8: same-cycle write and read of bank 0 address 2
    prodWrEn = 1'b1;
    prodAddr = 2;
    prodData = 16'h5555;
    consAddr = 2;
    @(negedge clk);
    prodWrEn = 1'b0;
    chk("R8", 32'(consData), 32'h1002);
    @(negedge clk);
    chk("R8", 32'(consData), 32'h5555);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule